// File: doc/BRIEF.md
# Floating-point exception flag collector

This block sits beside a floating-point unit. It takes the status conditions that each operation reports and gathers them into the sticky flag bits of a floating-point control/status register. Many separate invalid-operation causes fold into one invalid flag. A few of those causes also set their own signalling-NaN, quiet-NaN or infinity flag.

Conditions are gathered only while the register's exception-enable bit is set. After an accepted status strobe, the block raises a floating-point exception request if any of the eight hardware flags is set in the resulting register. The request carries the PC of the previous instruction. Software reads the register through `csr_q` and overwrites it through a single write port. A write is the only way to clear flags.

Top module: `fpflag_collector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `csr_q` is zero and `exc_req` is 0.
- R2: A status strobe is ignored while enable bit 0 of the effective register value is clear. The register keeps its value and no request is raised.
- R3: Each `st_cond` bit 0..8 (0 signalling NaN, 1 quiet NaN, 2 inf-inf, 3 inf/inf, 4 0/0, 5 inf*0, 6 bad conversion, 7 bad compare, 8 bad square root) sets the invalid flag at register bit 9.
- R4: `st_cond` bit 0 also sets bit 5 (signalling NaN), and bit 1 also sets bit 6 (quiet NaN).
- R5: Infinity flag bit 10 is set only by `st_cond` bit 2 or 3. No other condition sets it.
- R6: Overflow (`st_cond` bit 9) sets bit 3. Underflow (bit 10) sets bit 4. Divide by zero (bit 11) sets bit 11. Inexact (bit 12) sets bit 8.
- R7: Flags are sticky. Hardware only ORs them in, and only a software write clears them.
- R8: A software write takes priority over a status update in the same cycle. The new flags are ORed on top of the written value, gated by the written enable bit.
- R9: In the cycle after an accepted strobe, `exc_req` is 1 exactly when any of bits 3,4,5,6,8,9,10,11 is set in the new register value. `exc_pc` then holds the `prev_pc` of the strobe cycle. Bit 7 alone raises no request, and no request is raised without an accepted strobe.
- R10: A software write stores bits 11:0, including rounding mode bits 2:1 and zero flag bit 7. Bits above 11 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Status conditions valid this cycle |
| st_cond | input | 13 | Per-operation condition vector |
| prev_pc | input | PC_W | PC of the previous instruction |
| wr_en | input | 1 | Software register write strobe |
| wr_data | input | REG_W | Software write value |
| csr_q | output | REG_W | Current register value |
| exc_req | output | 1 | Floating-point exception request |
| exc_pc | output | PC_W | PC reported with the request |

## Verification
Each condition bit is first driven alone with the enable set. This separates the invalid merge from the dedicated NaN and infinity flags, and shows that no unrelated flag is touched. Strobes with the enable clear, strobes that leave only the zero flag set, and writes that collide with strobes tell the gating, the request mask and the write priority apart. A long stretch of random condition vectors, mixed with occasional random writes, then tests the sticky OR and the request against a bench model.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;
   // condition vector bit positions
   localparam int COND_W       = 13;
   localparam int C_SNAN       = 0;
   localparam int C_QNAN       = 1;
   localparam int C_INF_SUB    = 2;
   localparam int C_INF_DIV    = 3;
   localparam int C_ZERO_DIV   = 4;
   localparam int C_INF_MUL    = 5;
   localparam int C_BAD_CVT    = 6;
   localparam int C_BAD_CMP    = 7;
   localparam int C_BAD_SQRT   = 8;
   localparam int C_OVERFLOW   = 9;
   localparam int C_UNDERFLOW  = 10;
   localparam int C_DIVZERO    = 11;
   localparam int C_INEXACT    = 12;

   // register field positions
   localparam int USED_W = 12;
   localparam int F_EN   = 0;
   localparam int F_RM0  = 1;
   localparam int F_RM1  = 2;
   localparam int F_OVF  = 3;
   localparam int F_UNF  = 4;
   localparam int F_SNF  = 5;
   localparam int F_QNF  = 6;
   localparam int F_ZF   = 7;
   localparam int F_IXF  = 8;
   localparam int F_IVF  = 9;
   localparam int F_INF  = 10;
   localparam int F_DZF  = 11;

   // conditions that feed a given register bit
   function automatic logic [COND_W-1:0] cause_mask(input int fbit);
      logic [COND_W-1:0] m;
      m = '0;
      case (fbit)
         F_IVF: for (int c = C_SNAN; c <= C_BAD_SQRT; c++) m[c] = 1'b1;
         F_SNF: m[C_SNAN]      = 1'b1;
         F_QNF: m[C_QNAN]      = 1'b1;
         F_INF: begin m[C_INF_SUB] = 1'b1; m[C_INF_DIV] = 1'b1; end
         F_OVF: m[C_OVERFLOW]  = 1'b1;
         F_UNF: m[C_UNDERFLOW] = 1'b1;
         F_DZF: m[C_DIVZERO]   = 1'b1;
         F_IXF: m[C_INEXACT]   = 1'b1;
         default: m = '0;
      endcase
      return m;
   endfunction

   // register bits that raise an exception
   function automatic logic [USED_W-1:0] raise_mask();
      logic [USED_W-1:0] m;
      m = '0;
      m[F_OVF] = 1'b1; m[F_UNF] = 1'b1; m[F_SNF] = 1'b1; m[F_QNF] = 1'b1;
      m[F_IXF] = 1'b1; m[F_IVF] = 1'b1; m[F_INF] = 1'b1; m[F_DZF] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/fpflag_decode.sv
module fpflag_decode
   import fpflag_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic [COND_W-1:0] st_cond,
   output logic [REG_W-1:0]  hw_flags
);
   generate
      if (REG_W < USED_W) begin : g_bad_w
         $error("fpflag_decode: REG_W must be at least %0d", USED_W);
      end
      for (genvar f = 0; f < REG_W; f++) begin : g_bit
         if (f < USED_W) begin : g_live
            localparam logic [COND_W-1:0] CM = cause_mask(f);
            assign hw_flags[f] = |(st_cond & CM);
         end else begin : g_dead
            assign hw_flags[f] = 1'b0;
         end
      end
   endgenerate

   // R5: the infinity flag never rises without one of its two causes
   always_comb begin
      a_inf_only_r5: assert (!hw_flags[F_INF] || st_cond[C_INF_SUB] || st_cond[C_INF_DIV]);
   end
endmodule

// File: rtl/fpflag_csr.sv
module fpflag_csr
   import fpflag_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             st_valid,
   input  logic [REG_W-1:0] hw_flags,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] csr_q,
   output logic [REG_W-1:0] csr_nxt,
   output logic             upd_ok
);
   localparam logic [REG_W-1:0] WMASK = REG_W'({USED_W{1'b1}});
   localparam logic [REG_W-1:0] FMASK = REG_W'(raise_mask()) | (REG_W'(1) << F_ZF);

   logic [REG_W-1:0] base;

   always_comb begin
      base    = wr_en ? (wr_data & WMASK) : csr_q;
      upd_ok  = st_valid && base[F_EN];
      csr_nxt = upd_ok ? (base | hw_flags) : base;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) csr_q <= '0;
      else        csr_q <= csr_nxt;
   end

   // R7: without a write, no flag bit ever drops
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((csr_q & $past(csr_q) & FMASK) == ($past(csr_q) & FMASK)));
   // R2: enable clear and no write keeps the register frozen
   p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !csr_q[F_EN]) |=> $stable(csr_q));
   // R8/R10: a lone write lands as written in the low bits
   p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !st_valid) |=> (csr_q == ($past(wr_data) & WMASK)));
endmodule

// File: rtl/fpflag_raise.sv
module fpflag_raise
   import fpflag_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int PC_W      = 32,
   parameter bit RAISE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_ok,
   input  logic [REG_W-1:0] csr_nxt,
   input  logic [PC_W-1:0]  prev_pc,
   output logic             exc_req,
   output logic [PC_W-1:0]  exc_pc
);
   localparam logic [REG_W-1:0] RMASK = REG_W'(raise_mask());

   logic req_set;
   assign req_set = upd_ok && |(csr_nxt & RMASK);

   generate
      if (RAISE_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               exc_req <= 1'b0;
               exc_pc  <= '0;
            end else begin
               exc_req <= req_set;
               if (req_set) exc_pc <= prev_pc;
            end
         end
         // R9: request follows an accepted strobe with flags, carrying its PC
         p_req_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
            req_set |=> (exc_req && exc_pc == $past(prev_pc)));
         // R9: no request without an accepted strobe
         p_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_ok |=> !exc_req);
      end else begin : g_comb
         assign exc_req = req_set;
         assign exc_pc  = prev_pc;
      end
   endgenerate
endmodule

// File: rtl/fpflag_collector.sv
module fpflag_collector
   import fpflag_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int PC_W      = 32,
   parameter bit RAISE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [COND_W-1:0] st_cond,
   input  logic [PC_W-1:0]   prev_pc,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  csr_q,
   output logic              exc_req,
   output logic [PC_W-1:0]   exc_pc
);
   generate
      if (PC_W < 2) begin : g_bad_pc
         $error("fpflag_collector: PC_W too small");
      end
   endgenerate

   logic [REG_W-1:0] hw_flags;
   logic [REG_W-1:0] csr_nxt;
   logic             upd_ok;

   fpflag_decode #(.REG_W(REG_W)) dec_i (
      .st_cond(st_cond), .hw_flags(hw_flags));

   fpflag_csr #(.REG_W(REG_W)) csr_i (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .hw_flags(hw_flags),
      .wr_en(wr_en), .wr_data(wr_data), .csr_q(csr_q), .csr_nxt(csr_nxt),
      .upd_ok(upd_ok));

   fpflag_raise #(.REG_W(REG_W), .PC_W(PC_W), .RAISE_REG(RAISE_REG)) raise_i (
      .clk(clk), .rst_n(rst_n), .upd_ok(upd_ok), .csr_nxt(csr_nxt),
      .prev_pc(prev_pc), .exc_req(exc_req), .exc_pc(exc_pc));

   // R10: bits above the used field stay zero
   p_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((csr_q >> USED_W) == '0));
endmodule

// File: tb/fpflag_collector_tb_top.sv
module fpflag_collector_tb_top;
   localparam int REG_W = 32;
   localparam int PC_W  = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              st_valid = 1'b0;
   logic [12:0]       st_cond = '0;
   logic [PC_W-1:0]   prev_pc = '0;
   logic              wr_en = 1'b0;
   logic [REG_W-1:0]  wr_data = '0;
   logic [REG_W-1:0]  csr_q;
   logic              exc_req;
   logic [PC_W-1:0]   exc_pc;

   int n_chk = 0;
   int n_bad = 0;
   logic [11:0] exp_csr = '0;

   always #5 clk = ~clk;

   fpflag_collector #(.REG_W(REG_W), .PC_W(PC_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_cond(st_cond),
      .prev_pc(prev_pc), .wr_en(wr_en), .wr_data(wr_data), .csr_q(csr_q),
      .exc_req(exc_req), .exc_pc(exc_pc));

   function automatic logic [11:0] flags_of(input logic [12:0] c);
      logic [11:0] f;
      f = '0;
      f[9]  = |c[8:0];
      f[5]  = c[0];
      f[6]  = c[1];
      f[10] = c[2] | c[3];
      f[3]  = c[9];
      f[4]  = c[10];
      f[11] = c[11];
      f[8]  = c[12];
      return f;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // drive one cycle at negedge, check after the next posedge
   task automatic step(input string tag, input logic v, input logic [12:0] c,
                       input logic [PC_W-1:0] pc, input logic we, input logic [REG_W-1:0] wd);
      logic [11:0] base;
      logic        ereq;
      st_valid = v; st_cond = c; prev_pc = pc; wr_en = we; wr_data = wd;
      base = we ? wd[11:0] : exp_csr;
      if (v && base[0]) base = base | flags_of(c);
      ereq = v && base[0] && |(base & 12'hF78);
      exp_csr = base;
      @(posedge clk);
      @(negedge clk);
      st_valid = 1'b0; wr_en = 1'b0;
      check({tag, " csr"}, 64'(csr_q), 64'(exp_csr));
      check({tag, " req"}, 64'(exc_req), 64'(ereq));
      if (ereq) check({tag, " pc"}, 64'(exc_pc), 64'(pc));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      check("R1 reset csr", 64'(csr_q), 64'd0);
      check("R1 reset req", 64'(exc_req), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset csr", 64'(csr_q), 64'd0);
      check("R1 after reset req", 64'(exc_req), 64'd0);

      // R2: enable clear -> strobes ignored
      step("R2 disabled strobe", 1'b1, 13'h1FFF, 32'h100, 1'b0, '0);
      step("R2 disabled strobe2", 1'b1, 13'h0200, 32'h104, 1'b0, '0);

      // R10: write with rounding mode, zero flag and high bits
      step("R10 write rm zf hi", 1'b0, '0, '0, 1'b1, 32'hFFFF_F086);
      // R9: zero flag alone raises nothing even with enable set
      step("R9 zf only", 1'b1, '0, 32'h200, 1'b1, 32'h0000_0081);

      // R3 R4 R5 R6: each condition alone, from a clean enabled register
      for (int c = 0; c < 13; c++) begin
         step("R3 R4 R5 R6 clear", 1'b0, '0, '0, 1'b1, 32'h1);
         step($sformatf("R3 R4 R5 R6 cond %0d", c), 1'b1, 13'(1) << c,
              32'h1000 + 32'(c) * 4, 1'b0, '0);
      end

      // R7: sticky across strobes with no conditions
      step("R7 set ovf", 1'b1, 13'h0200, 32'h300, 1'b0, '0);
      step("R7 set unf", 1'b1, 13'h0400, 32'h304, 1'b0, '0);
      step("R7 empty strobe", 1'b1, 13'h0000, 32'h308, 1'b0, '0);
      step("R7 idle", 1'b0, 13'h0000, 32'h30C, 1'b0, '0);

      // R8: collision, write clears and new flags OR on top
      step("R8 collide", 1'b1, 13'h1000, 32'h400, 1'b1, 32'h1);
      // R8: collision where write disables enable -> strobe dropped
      step("R8 collide disable", 1'b1, 13'h0800, 32'h404, 1'b1, 32'h0);
      // R8: collision where write enables
      step("R8 collide enable", 1'b1, 13'h0800, 32'h408, 1'b1, 32'h5);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         logic [12:0] c;
         r = $urandom();
         c = 13'($urandom()) & 13'($urandom());
         step("R7 R9 random", r[0] | r[1], c, $urandom(), (r[7:4] == 4'd0),
              {$urandom()} | 32'(r[8] | r[9]));
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule